// File: doc/BRIEF.md
# Five-Port Micro-Op Dispatch Scheduler

This block is the dispatch stage between a pool of operand-ready micro-ops and five execution ports. It looks at every pool slot each clock, chooses at most one micro-op per port, and reports which slots were taken. It also models the functional units behind the ports. A divider stays busy for its whole latency. A multiplier shared by integer and floating-point multiplies takes floating-point work only every other clock. A branch unit cannot accept branches in two consecutive clocks. A store-data path may hold only a bounded number of outstanding stores. Each issued micro-op produces a completion event on its port exactly its class latency later.

Each pool slot is a valid/ready stream. A slot holds its micro-op, with class and tag stable, while `in_valid` is high. The slot is consumed in a clock where `in_valid` and `in_ready` are both high. A slot that is not granted keeps waiting; this is the only back-pressure. Slot 0 is the oldest and higher indices are younger. The issue and completion outputs are single-cycle pulses with no back-pressure. `st_free` is a plain pulse from the store path that returns one store buffer.

Class codes on `in_cls`:
- 0 simple ALU
- 1 shift/rotate
- 2 FP add
- 3 integer multiply
- 4 FP multiply
- 5 divide
- 6 branch
- 7 load
- 8 store address
- 9 store data

Top module: `uop_dispatch5`

## Requirements
- R1: While `rst_n` is low, no slot is granted, no port issues and no completion is signalled. After reset all units are idle and no store buffer is in use.
- R2: Ports map to classes as follows. Port 0 takes shift (1), FP add (2), integer multiply (3), FP multiply (4) and divide (5). Port 1 takes branch (6). Port 2 takes load (7), port 3 takes store address (8) and port 4 takes store data (9). All five ports can issue in the same clock.
- R3: A simple ALU micro-op (0) may use port 0 or port 1. Port 0 takes the oldest micro-op it can accept. Port 1 then takes the oldest remaining ALU or branch it can accept, so two ALU micro-ops go to port 0 (older) and port 1 (younger) together.
- R4: Each port issues at most one micro-op per clock, always the oldest eligible slot. `in_ready` is high in a clock exactly for the slots issued in that clock.
- R5: A micro-op issued in clock t signals `done_valid` on its port with its tag in clock t+L. L is 1 for ALU, shift, branch, store address and store data. L is 3 for FP add and load, 4 for integer multiply, 5 for FP multiply and 39 for divide.
- R6: A port-0 micro-op is held if its completion would fall in the same clock as a completion already booked on port 0. An ALU micro-op held this way goes to port 1 if port 1 can take it.
- R7: In the clock after an FP multiply issues, neither an FP multiply nor an integer multiply issues.
- R8: After a divide issues in clock t, the next divide issues no earlier than clock t+39. Other port-0 work may still issue in between.
- R9: A branch never issues in the clock right after a branch issue.
- R10: Store data micro-ops issue in pool order, at most 4 outstanding. A `st_free` pulse in clock t lets a waiting store data micro-op issue in clock t+1, but not in clock t.
- R11: A slot with `in_valid` low, or with a class code of 10 to 15, is never granted and causes no issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | SLOTS | Per-slot micro-op present; bit 0 is the oldest |
| in_cls | input | 4*SLOTS | Per-slot class code, slot i at bits [4i+3:4i] |
| in_tag | input | TAGW*SLOTS | Per-slot tag |
| in_ready | output | SLOTS | Slot issued this clock |
| st_free | input | 1 | One store buffer released |
| iss_valid | output | 5 | Per-port issue pulse |
| iss_tag | output | 5*TAGW | Per-port issued tag |
| done_valid | output | 5 | Per-port completion pulse |
| done_tag | output | 5*TAGW | Per-port completed tag |

## Verification
Errors in the internal state show up at the ports in one of two ways. A wrong divider counter or wrong multiply or branch hold shows at once as a micro-op issued or refused in the wrong clock. A corrupt completion booking shows later, as a missing, early or shifted `done_valid`. For a divide that can be up to 39 clocks after the issue. A store-buffer count that drifts shows only when the fifth store data micro-op arrives: it either issues early or stays stuck after `st_free`. The directed scenarios therefore keep running until each of these latencies and limits has been reached.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef enum logic [3:0] {
    C_ALU  = 4'd0,
    C_SHF  = 4'd1,
    C_FADD = 4'd2,
    C_IMUL = 4'd3,
    C_FMUL = 4'd4,
    C_DIV  = 4'd5,
    C_BR   = 4'd6,
    C_LD   = 4'd7,
    C_STA  = 4'd8,
    C_STD  = 4'd9
  } op_cls_e;

  localparam int NPORT = 5;
  localparam int CLSW  = 4;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dsp_oldest_pick.sv
module dsp_oldest_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic found;
  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsp_done_pipe.sv
module dsp_done_pipe #(
  parameter int DEPTH = 4,
  parameter int TAGW  = 4,
  parameter int LW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins,
  input  logic [LW-1:0]    ins_lat,
  input  logic [TAGW-1:0]  ins_tag,
  output logic [DEPTH-1:0] occ,
  output logic             done_v,
  output logic [TAGW-1:0]  done_tag
);
  logic [DEPTH-1:0]      v, v_n;
  logic [DEPTH*TAGW-1:0] t, t_n;

  always_comb begin
    v_n = v >> 1;
    t_n = t >> TAGW;
    if (ins) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (ins_lat == LW'(k + 1)) begin
          v_n[k]               = 1'b1;
          t_n[k*TAGW +: TAGW]  = ins_tag;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v <= '0;
      t <= '0;
    end else begin
      v <= v_n;
      t <= t_n;
    end
  end

  assign occ      = v;
  assign done_v   = v[0];
  assign done_tag = t[TAGW-1:0];

  // R6: a new booking never lands on a slot already holding a completion
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    ins |-> !(|(v & (DEPTH'(1) << ins_lat))));
endmodule

// File: rtl/dsp_unit_occ.sv
module dsp_unit_occ #(
  parameter int DIV_LAT  = 39,
  parameter int SB_DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_go,
  input  logic fmul_go,
  input  logic mul_go,
  input  logic br_go,
  input  logic std_go,
  input  logic st_free,
  output logic div_busy,
  output logic mul_hold,
  output logic br_hold,
  output logic sb_full
);
  localparam int DW = $clog2(DIV_LAT + 1);
  localparam int SW = $clog2(SB_DEPTH + 1);

  logic [DW-1:0] div_cnt;
  logic [SW-1:0] sb_cnt;
  logic          rel;

  assign rel = st_free && (sb_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      sb_cnt   <= '0;
      mul_hold <= 1'b0;
      br_hold  <= 1'b0;
    end else begin
      if (div_go)               div_cnt <= DW'(DIV_LAT - 1);
      else if (div_cnt != '0)   div_cnt <= div_cnt - DW'(1);
      mul_hold <= fmul_go;
      br_hold  <= br_go;
      if (std_go && !rel)       sb_cnt <= sb_cnt + SW'(1);
      else if (!std_go && rel)  sb_cnt <= sb_cnt - SW'(1);
    end
  end

  assign div_busy = (div_cnt != '0);
  assign sb_full  = (sb_cnt >= SW'(SB_DEPTH));

  a_r8_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> (div_cnt == '0));
  a_r7_mul_gap: assert property (@(posedge clk) disable iff (!rst_n)
    fmul_go |=> !mul_go);
  a_r9_br_gap: assert property (@(posedge clk) disable iff (!rst_n)
    br_go |=> !br_go);
  a_r10_sb_cap: assert property (@(posedge clk) disable iff (!rst_n)
    std_go |-> (sb_cnt < SW'(SB_DEPTH)));
  a_r10_sb_range: assert property (@(posedge clk) disable iff (!rst_n)
    sb_cnt <= SW'(SB_DEPTH));
endmodule

// File: rtl/uop_dispatch5.sv
module uop_dispatch5 import dsp_pkg::*; #(
  parameter int SLOTS    = 6,
  parameter int TAGW     = 4,
  parameter int LAT_ALU  = 1,
  parameter int LAT_SHF  = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_IMUL = 4,
  parameter int LAT_FMUL = 5,
  parameter int LAT_DIV  = 39,
  parameter int LAT_BR   = 1,
  parameter int LAT_LD   = 3,
  parameter int LAT_STA  = 1,
  parameter int LAT_STD  = 1,
  parameter int SB_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOTS-1:0]       in_valid,
  input  logic [CLSW*SLOTS-1:0]  in_cls,
  input  logic [TAGW*SLOTS-1:0]  in_tag,
  output logic [SLOTS-1:0]       in_ready,
  input  logic                   st_free,
  output logic [NPORT-1:0]       iss_valid,
  output logic [NPORT*TAGW-1:0]  iss_tag,
  output logic [NPORT-1:0]       done_valid,
  output logic [NPORT*TAGW-1:0]  done_tag
);
  localparam int D0 = max2(max2(max2(LAT_DIV, LAT_FMUL), max2(LAT_IMUL, LAT_FADD)),
                           max2(LAT_ALU, LAT_SHF));
  localparam int D1 = max2(LAT_ALU, LAT_BR);
  localparam int MAXD = max2(max2(D0, D1), max2(LAT_LD, max2(LAT_STA, LAT_STD)));
  localparam int LWM  = $clog2(MAXD + 1);

  function automatic int port_depth(int p);
    case (p)
      0: return D0;
      1: return D1;
      2: return LAT_LD;
      3: return LAT_STA;
      default: return LAT_STD;
    endcase
  endfunction

  function automatic int lat_of(logic [CLSW-1:0] c);
    case (c)
      C_ALU:  return LAT_ALU;
      C_SHF:  return LAT_SHF;
      C_FADD: return LAT_FADD;
      C_IMUL: return LAT_IMUL;
      C_FMUL: return LAT_FMUL;
      C_DIV:  return LAT_DIV;
      C_BR:   return LAT_BR;
      C_LD:   return LAT_LD;
      C_STA:  return LAT_STA;
      default: return LAT_STD;
    endcase
  endfunction

  function automatic logic slot_free(logic [MAXD-1:0] o, int l);
    logic [MAXD-1:0] s;
    if (l >= MAXD) return 1'b1;
    s = o >> l;
    return !s[0];
  endfunction

  logic [MAXD-1:0] occ [NPORT];
  logic            div_busy, mul_hold, br_hold, sb_full;

  logic [SLOTS-1:0] e0, e1, e2, e3, e4;
  logic [SLOTS-1:0] is_div, is_fmul, is_mul, is_br;
  logic [LWM-1:0]   lat_i [SLOTS];
  logic [SLOTS-1:0] g0, g1, g2, g3, g4;
  logic [SLOTS-1:0] r1;

  // per-slot eligibility on each port
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      logic [CLSW-1:0] c;
      logic            ok;
      int              l;
      c  = in_cls[i*CLSW +: CLSW];
      l  = lat_of(c);
      ok = in_valid[i] && rst_n;
      lat_i[i]   = LWM'(l);
      e0[i] = 1'b0; e1[i] = 1'b0; e2[i] = 1'b0; e3[i] = 1'b0; e4[i] = 1'b0;
      is_div[i]  = (c == C_DIV);
      is_fmul[i] = (c == C_FMUL);
      is_mul[i]  = (c == C_FMUL) || (c == C_IMUL);
      is_br[i]   = (c == C_BR);
      case (c)
        C_ALU: begin
          e0[i] = ok && slot_free(occ[0], l);
          e1[i] = ok && slot_free(occ[1], l);
        end
        C_SHF, C_FADD:  e0[i] = ok && slot_free(occ[0], l);
        C_IMUL, C_FMUL: e0[i] = ok && !mul_hold && slot_free(occ[0], l);
        C_DIV:          e0[i] = ok && !div_busy && slot_free(occ[0], l);
        C_BR:           e1[i] = ok && !br_hold && slot_free(occ[1], l);
        C_LD:           e2[i] = ok;
        C_STA:          e3[i] = ok;
        C_STD:          e4[i] = ok && !sb_full;
        default: ;
      endcase
    end
  end

  assign r1 = e1 & ~g0;

  dsp_oldest_pick #(.N(SLOTS)) u_pick0 (.req(e0), .gnt(g0));
  dsp_oldest_pick #(.N(SLOTS)) u_pick1 (.req(r1), .gnt(g1));
  dsp_oldest_pick #(.N(SLOTS)) u_pick2 (.req(e2), .gnt(g2));
  dsp_oldest_pick #(.N(SLOTS)) u_pick3 (.req(e3), .gnt(g3));
  dsp_oldest_pick #(.N(SLOTS)) u_pick4 (.req(e4), .gnt(g4));

  logic [NPORT-1:0][SLOTS-1:0] gnt;
  logic [LWM-1:0]              lat_sel [NPORT];
  assign gnt = {g4, g3, g2, g1, g0};

  always_comb begin
    in_ready = g0 | g1 | g2 | g3 | g4;
    for (int p = 0; p < NPORT; p++) begin
      iss_valid[p]              = |gnt[p];
      iss_tag[p*TAGW +: TAGW]   = '0;
      lat_sel[p]                = '0;
      for (int i = 0; i < SLOTS; i++) begin
        if (gnt[p][i]) begin
          iss_tag[p*TAGW +: TAGW] = iss_tag[p*TAGW +: TAGW] | in_tag[i*TAGW +: TAGW];
          lat_sel[p]              = lat_sel[p] | lat_i[i];
        end
      end
    end
  end

  dsp_unit_occ #(.DIV_LAT(LAT_DIV), .SB_DEPTH(SB_DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n),
    .div_go(|(g0 & is_div)), .fmul_go(|(g0 & is_fmul)), .mul_go(|(g0 & is_mul)),
    .br_go(|(g1 & is_br)), .std_go(|g4), .st_free(st_free),
    .div_busy(div_busy), .mul_hold(mul_hold), .br_hold(br_hold), .sb_full(sb_full)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int D = port_depth(p);
    logic [D-1:0] po;
    dsp_done_pipe #(.DEPTH(D), .TAGW(TAGW), .LW(LWM)) u_done (
      .clk(clk), .rst_n(rst_n),
      .ins(iss_valid[p]), .ins_lat(lat_sel[p]), .ins_tag(iss_tag[p*TAGW +: TAGW]),
      .occ(po), .done_v(done_valid[p]), .done_tag(done_tag[p*TAGW +: TAGW])
    );
    assign occ[p] = MAXD'(po);
  end

  // R11: only presented slots are ever consumed
  a_r11_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);
  // R4: a slot is consumed by one port only
  a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_valid) == $countones(in_ready));
endmodule

// File: tb/uop_dispatch5_bench.sv
`timescale 1ns/1ps
module uop_dispatch5_bench;
  localparam int SLOTS = 6;
  localparam int TAGW  = 4;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic [SLOTS-1:0]      in_valid;
  logic [4*SLOTS-1:0]    in_cls;
  logic [TAGW*SLOTS-1:0] in_tag;
  logic [SLOTS-1:0]      in_ready;
  logic                  st_free;
  logic [4:0]            iss_valid;
  logic [5*TAGW-1:0]     iss_tag;
  logic [4:0]            done_valid;
  logic [5*TAGW-1:0]     done_tag;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uop_dispatch5 u_uop_dispatch5 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls), .in_tag(in_tag),
    .in_ready(in_ready), .st_free(st_free), .iss_valid(iss_valid), .iss_tag(iss_tag),
    .done_valid(done_valid), .done_tag(done_tag)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int itag(int p); return int'(iss_tag[p*TAGW +: TAGW]); endfunction
  function automatic int dtag(int p); return int'(done_tag[p*TAGW +: TAGW]); endfunction

  task automatic put(input int i, input int c, input int t);
    in_valid[i]            = 1'b1;
    in_cls[i*4 +: 4]       = 4'(c);
    in_tag[i*TAGW +: TAGW] = TAGW'(t);
  endtask

  task automatic clr(); in_valid = '0; endtask
  task automatic settle(); #1; endtask

  // advance one clock, removing slots that were consumed
  task automatic tick();
    logic [SLOTS-1:0] taken;
    taken = in_ready;
    @(posedge clk);
    @(negedge clk);
    in_valid = in_valid & ~taken;
    #1;
  endtask

  task automatic t_reset();
    put(0, 0, 1);
    settle();
    chk("R1 ready in reset", int'(in_ready), 0);
    chk("R1 issue in reset", int'(iss_valid), 0);
    chk("R1 done in reset", int'(done_valid), 0);
    clr();
  endtask

  task automatic t_dual_alu();
    put(0, 0, 1); put(1, 0, 2);
    settle();
    chk("R3 issue mask", int'(iss_valid), 5'b00011);
    chk("R3 port0 oldest", itag(0), 1);
    chk("R3 port1 younger", itag(1), 2);
    chk("R4 ready mask", int'(in_ready), 6'b000011);
    tick();
    chk("R5 alu done mask", int'(done_valid), 5'b00011);
    chk("R5 alu done tag p0", dtag(0), 1);
    chk("R5 alu done tag p1", dtag(1), 2);
  endtask

  task automatic t_all_ports();
    put(0, 6, 3); put(1, 1, 4); put(2, 7, 5); put(3, 8, 6); put(4, 9, 7);
    settle();
    chk("R2 five ports", int'(iss_valid), 5'b11111);
    chk("R2 port0 shift", itag(0), 4);
    chk("R2 port1 branch", itag(1), 3);
    chk("R2 port2 load", itag(2), 5);
    chk("R2 port3 sta", itag(3), 6);
    chk("R2 port4 std", itag(4), 7);
    tick();
    chk("R5 lat1 done mask", int'(done_valid), 5'b11011);
    st_free = 1'b1;
    tick();
    st_free = 1'b0;
    chk("R5 load not early", int'(done_valid[2]), 0);
    tick();
    chk("R5 load done", int'(done_valid[2]), 1);
    chk("R5 load tag", dtag(2), 5);
  endtask

  task automatic t_fadd_lat();
    put(0, 2, 8);
    settle();
    chk("R2 fadd on port0", itag(0), 8);
    tick(); chk("R5 fadd +1", int'(done_valid[0]), 0);
    tick(); chk("R5 fadd +2", int'(done_valid[0]), 0);
    tick(); chk("R5 fadd +3", int'(done_valid[0]), 1);
    chk("R5 fadd tag", dtag(0), 8);
  endtask

  task automatic t_collision();
    put(0, 3, 9);
    settle();
    chk("R6 imul issues", itag(0), 9);
    tick();
    put(0, 2, 10);
    settle();
    chk("R6 fadd held", int'(iss_valid[0]), 0);
    tick();
    chk("R6 fadd issues later", itag(0), 10);
    chk("R6 fadd valid", int'(iss_valid[0]), 1);
    tick();
    tick();
    chk("R5 imul done t+4", dtag(0), 9);
    chk("R5 imul done valid", int'(done_valid[0]), 1);
    put(0, 0, 11);
    settle();
    chk("R6 alu off port0", int'(iss_valid[0]), 0);
    chk("R6 alu on port1", itag(1), 11);
    tick();
    chk("R6 fadd done", dtag(0), 10);
    chk("R6 alu done p1", dtag(1), 11);
  endtask

  task automatic t_mul_rate();
    put(0, 4, 12); put(1, 3, 13);
    settle();
    chk("R7 fmul issues", itag(0), 12);
    chk("R7 ready only fmul", int'(in_ready), 1);
    tick();
    chk("R7 imul blocked", int'(iss_valid[0]), 0);
    tick();
    chk("R7 imul issues", itag(0), 13);
    repeat (6) tick();
  endtask

  task automatic t_divide();
    int k;
    put(0, 5, 1);
    settle();
    chk("R8 div issues", itag(0), 1);
    tick();
    put(0, 5, 2); put(1, 0, 3);
    settle();
    chk("R8 port0 takes alu", itag(0), 3);
    chk("R8 second div waits", int'(in_ready[0]), 0);
    tick();
    k = 2;
    while (iss_valid[0] !== 1'b1 && k < 60) begin tick(); k++; end
    chk("R8 div spacing", k, 39);
    chk("R8 second div tag", itag(0), 2);
    chk("R5 div done tag", dtag(0), 1);
    repeat (40) tick();
  endtask

  task automatic t_branch();
    put(0, 6, 4); put(1, 6, 5);
    settle();
    chk("R9 first branch", itag(1), 4);
    tick();
    chk("R9 gap", int'(iss_valid[1]), 0);
    tick();
    chk("R9 second branch", itag(1), 5);
    tick();
  endtask

  task automatic t_stores();
    for (int i = 0; i < 5; i++) put(i, 9, i + 1);
    settle();
    for (int i = 0; i < 4; i++) begin
      chk("R10 store order", itag(4), i + 1);
      tick();
    end
    chk("R10 fifth blocked", int'(iss_valid[4]), 0);
    st_free = 1'b1;
    settle();
    chk("R10 not same clock", int'(iss_valid[4]), 0);
    tick();
    st_free = 1'b0;
    settle();
    chk("R10 fifth issues", itag(4), 5);
    tick();
    st_free = 1'b1;
    repeat (5) tick();
    st_free = 1'b0;
  endtask

  task automatic t_oldest_load();
    put(1, 7, 6); put(3, 7, 7);
    settle();
    chk("R4 oldest load ready", int'(in_ready), 6'b000010);
    chk("R4 oldest load tag", itag(2), 6);
    tick();
    chk("R4 next load", itag(2), 7);
    tick();
  endtask

  task automatic t_ignored();
    put(0, 12, 1);
    put(1, 0, 2);
    in_valid[1] = 1'b0;
    settle();
    chk("R11 no ready", int'(in_ready), 0);
    chk("R11 no issue", int'(iss_valid), 0);
    tick();
    chk("R11 no done", int'(done_valid), 0);
    clr();
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = '0; in_cls = '0; in_tag = '0; st_free = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    chk("R1 idle after reset", int'(done_valid), 0);
    t_dual_alu();
    t_all_ports();
    tick();
    t_fadd_lat();
    tick();
    t_collision();
    tick();
    t_mul_rate();
    t_divide();
    t_branch();
    t_stores();
    t_oldest_load();
    repeat (4) tick();
    t_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule